// File: doc/BRIEF.md
# JTAG Instruction Register and Data-Register Selector

This block sits beside an external TAP state controller and owns the instruction side of a JTAG port. It keeps a 4-bit instruction shift stage and an active instruction, and decodes the active instruction to pick which data register is placed between TDI and TDO. It holds three data registers of its own: a 32-bit identification register, a single bypass cell, and a single reset-control cell. The boundary-scan chain lives outside. The block gives that chain a select line, a drive-to-pins mode line and gated capture/shift/update strobes, and takes the chain's serial output back in.

The TAP controller supplies one-cycle-per-state strobes (capture, shift and update for both DR and IR, plus test-logic-reset). All state advances on the rising TCK edge. TDO is retimed on the falling edge, and it sits at a fixed idle level whenever neither shift state is active. The reset-control instruction routes TDI into a one-bit cell. That cell's value is the system reset request, live and without any update latch. Loading this instruction never resets the TAP controller or the instruction register.

Top module: `jtag_ir_dr_sel`

## Requirements
- R1: After `rst_n` is released, and on the rising TCK edge where `tlr` is high, the active instruction becomes IDCODE (0x1). The same `tlr` edge clears the reset-control cell.
- R2: On the `cap_ir` edge the instruction shift stage loads 4'b0001. On each `sft_ir` edge it shifts right, with TDI entering bit 3, and during Shift-IR TDO presents bit 0. The active instruction changes only on an `upd_ir` edge, where it copies the shift stage.
- R3: Under IDCODE (0x1), `cap_dr` loads `id_value` into the 32-bit ID register. Each `sft_dr` edge shifts it right with TDI entering the MSB, so TDO shows `id_value` least significant bit first.
- R4: Under BYPASS (0xF), `cap_dr` loads 0 into the bypass cell. Each `sft_dr` edge moves TDI into the cell, giving one cycle of delay from TDI to TDO.
- R5: Every opcode other than 0x0, 0x1, 0x2 and 0xC behaves exactly as BYPASS.
- R6: Under reset control (0xC), each `sft_dr` edge loads TDI into the reset cell, and `sys_rst_req` equals the cell from that same edge, including mid-shift. `cap_dr` and `upd_dr` have no effect on the cell.
- R7: Changing the instruction and shifting other data registers leave the reset cell and `sys_rst_req` unchanged. The reset-control instruction leaves the instruction register in its normal function.
- R8: Under EXTEST (0x0), `bsc_sel` and `bsc_drive` are both 1, starting right after the `upd_ir` edge that loads the opcode.
- R9: Under SAMPLE/PRELOAD (0x2), `bsc_sel` is 1 and `bsc_drive` is 0. Under both boundary opcodes, TDO during Shift-DR follows `bsc_so`, and `bsc_cap`/`bsc_shift`/`bsc_upd` copy `cap_dr`/`sft_dr`/`upd_dr`. Under any other instruction those four outputs are 0.
- R10: TDO changes only on the falling TCK edge. When neither `sft_dr` nor `sft_ir` is high it is 1, the default idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr | input | 1 | Test-logic-reset state strobe |
| cap_dr | input | 1 | Capture-DR state strobe |
| sft_dr | input | 1 | Shift-DR state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| cap_ir | input | 1 | Capture-IR state strobe |
| sft_ir | input | 1 | Shift-IR state strobe |
| upd_ir | input | 1 | Update-IR state strobe |
| tdi | input | 1 | Serial test data in |
| id_value | input | 32 | Identification constant (version, part, manufacturer) |
| bsc_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| sys_rst_req | output | 1 | System reset request from the reset cell |
| bsc_sel | output | 1 | Boundary chain is the selected data register |
| bsc_drive | output | 1 | Boundary output latches drive the pins |
| bsc_cap | output | 1 | Capture strobe gated for the boundary chain |
| bsc_shift | output | 1 | Shift strobe gated for the boundary chain |
| bsc_upd | output | 1 | Update strobe gated for the boundary chain |

## Verification
Strobes and TDI are applied 1 ns after a rising edge. Register state, `sys_rst_req` and the boundary mode lines are due right after the next rising edge. TDO is due half a cycle later, at the falling edge. The reference model advances at each rising edge, and all outputs are compared 4 ns after that edge, which is after the falling edge. A second comparison at 2 ns checks that TDO still holds the value from the previous cycle, so a rising-edge TDO would be caught.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;
   typedef enum logic [1:0] {
      SEL_BSC    = 2'd0,
      SEL_IDREG  = 2'd1,
      SEL_BYPASS = 2'd2,
      SEL_RSTREG = 2'd3
   } dr_sel_e;
endpackage

// File: rtl/jtag_ir_reg.sv
module jtag_ir_reg #(
   parameter int              IR_W     = 4,
   parameter logic [IR_W-1:0] RESET_OP = 1,
   parameter logic [IR_W-1:0] CAP_PAT  = 1
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tlr,
   input  logic            cap_ir,
   input  logic            sft_ir,
   input  logic            upd_ir,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_sh,
   output logic [IR_W-1:0] ir_act
);
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh  <= CAP_PAT;
         ir_act <= RESET_OP;
      end else if (tlr) begin
         ir_act <= RESET_OP;
      end else begin
         if (cap_ir)      ir_sh <= CAP_PAT;
         else if (sft_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
         if (upd_ir)      ir_act <= ir_sh;
      end
   end
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
   import jtag_sel_pkg::*;
#(
   parameter int              IR_W      = 4,
   parameter logic [IR_W-1:0] OP_EXTEST = 0,
   parameter logic [IR_W-1:0] OP_IDCODE = 1,
   parameter logic [IR_W-1:0] OP_SAMPLE = 2,
   parameter logic [IR_W-1:0] OP_RSTCTL = 12,
   parameter logic [IR_W-1:0] OP_BYPASS = 15
) (
   input  logic [IR_W-1:0] ir_act,
   output dr_sel_e         dr_sel,
   output logic            bsc_drive
);
   always_comb begin
      bsc_drive = 1'b0;
      case (ir_act)
         OP_EXTEST: begin dr_sel = SEL_BSC; bsc_drive = 1'b1; end
         OP_SAMPLE: dr_sel = SEL_BSC;
         OP_IDCODE: dr_sel = SEL_IDREG;
         OP_RSTCTL: dr_sel = SEL_RSTREG;
         OP_BYPASS: dr_sel = SEL_BYPASS;
         default:   dr_sel = SEL_BYPASS;
      endcase
   end
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
   import jtag_sel_pkg::*;
#(
   parameter int ID_W = 32
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tlr,
   input  logic            cap_dr,
   input  logic            sft_dr,
   input  logic            tdi,
   input  dr_sel_e         dr_sel,
   input  logic [ID_W-1:0] id_value,
   output logic            id_lsb,
   output logic            byp_cell,
   output logic            rst_cell
);
   logic [ID_W-1:0] id_sh;
   logic            is_id, is_byp, is_rst;

   assign is_id  = (dr_sel == SEL_IDREG);
   assign is_byp = (dr_sel == SEL_BYPASS);
   assign is_rst = (dr_sel == SEL_RSTREG);
   assign id_lsb = id_sh[0];

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         id_sh    <= '0;
         byp_cell <= 1'b0;
      end else begin
         if (is_id && cap_dr)      id_sh <= id_value;
         else if (is_id && sft_dr) id_sh <= {tdi, id_sh[ID_W-1:1]};
         if (is_byp && cap_dr)      byp_cell <= 1'b0;
         else if (is_byp && sft_dr) byp_cell <= tdi;
      end
   end

   // unlatched reset cell: shift only, no capture, no update
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)               rst_cell <= 1'b0;
      else if (tlr)             rst_cell <= 1'b0;
      else if (is_rst && sft_dr) rst_cell <= tdi;
   end
endmodule

// File: rtl/jtag_tdo_out.sv
module jtag_tdo_out #(
   parameter logic IDLE    = 1'b1,
   parameter bit   ON_FALL = 1'b1
) (
   input  logic tck,
   input  logic rst_n,
   input  logic shifting,
   input  logic bit_in,
   output logic tdo
);
   logic nxt;
   assign nxt = shifting ? bit_in : IDLE;

   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n) tdo <= IDLE;
            else        tdo <= nxt;
         end
      end else begin : g_rise
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n) tdo <= IDLE;
            else        tdo <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/jtag_ir_dr_sel.sv
module jtag_ir_dr_sel
   import jtag_sel_pkg::*;
#(
   parameter int              IR_W        = 4,
   parameter int              ID_W        = 32,
   parameter logic [IR_W-1:0] OP_EXTEST   = 4'h0,
   parameter logic [IR_W-1:0] OP_IDCODE   = 4'h1,
   parameter logic [IR_W-1:0] OP_SAMPLE   = 4'h2,
   parameter logic [IR_W-1:0] OP_RSTCTL   = 4'hC,
   parameter logic [IR_W-1:0] OP_BYPASS   = 4'hF,
   parameter logic [IR_W-1:0] IR_CAP_PAT  = 4'b0001,
   parameter logic            TDO_IDLE    = 1'b1,
   parameter bit              TDO_ON_FALL = 1'b1
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tlr,
   input  logic            cap_dr,
   input  logic            sft_dr,
   input  logic            upd_dr,
   input  logic            cap_ir,
   input  logic            sft_ir,
   input  logic            upd_ir,
   input  logic            tdi,
   input  logic [ID_W-1:0] id_value,
   input  logic            bsc_so,
   output logic            tdo,
   output logic            sys_rst_req,
   output logic            bsc_sel,
   output logic            bsc_drive,
   output logic            bsc_cap,
   output logic            bsc_shift,
   output logic            bsc_upd
);
   localparam int N_OPS = 5;
   localparam logic [N_OPS*IR_W-1:0] OP_LIST =
      {OP_EXTEST, OP_IDCODE, OP_SAMPLE, OP_RSTCTL, OP_BYPASS};

   // elaboration-time parameter checks
   if (IR_W < 2) begin : g_bad_irw
      $error("IR_W must be at least 2");
   end
   if (ID_W < 2) begin : g_bad_idw
      $error("ID_W must be at least 2");
   end
   if (IR_CAP_PAT[1:0] != 2'b01) begin : g_bad_cap
      $error("IR capture pattern must end in 01");
   end
   for (genvar i = 0; i < N_OPS; i++) begin : g_opchk
      for (genvar j = i + 1; j < N_OPS; j++) begin : g_pair
         if (OP_LIST[i*IR_W +: IR_W] == OP_LIST[j*IR_W +: IR_W]) begin : g_dup
            $error("two instructions share one opcode");
         end
      end
   end

   logic [IR_W-1:0] ir_sh, ir_act;
   dr_sel_e         dr_sel;
   logic            id_lsb, byp_cell, rst_cell;
   logic            sel_bit;

   jtag_ir_reg #(
      .IR_W(IR_W), .RESET_OP(OP_IDCODE), .CAP_PAT(IR_CAP_PAT)
   ) u_ir (
      .tck(tck), .rst_n(rst_n), .tlr(tlr), .cap_ir(cap_ir), .sft_ir(sft_ir),
      .upd_ir(upd_ir), .tdi(tdi), .ir_sh(ir_sh), .ir_act(ir_act)
   );

   jtag_ir_decode #(
      .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_IDCODE(OP_IDCODE),
      .OP_SAMPLE(OP_SAMPLE), .OP_RSTCTL(OP_RSTCTL), .OP_BYPASS(OP_BYPASS)
   ) u_dec (
      .ir_act(ir_act), .dr_sel(dr_sel), .bsc_drive(bsc_drive)
   );

   jtag_dr_bank #(.ID_W(ID_W)) u_drs (
      .tck(tck), .rst_n(rst_n), .tlr(tlr), .cap_dr(cap_dr), .sft_dr(sft_dr),
      .tdi(tdi), .dr_sel(dr_sel), .id_value(id_value), .id_lsb(id_lsb),
      .byp_cell(byp_cell), .rst_cell(rst_cell)
   );

   always_comb begin
      if (sft_ir) sel_bit = ir_sh[0];
      else begin
         case (dr_sel)
            SEL_IDREG:  sel_bit = id_lsb;
            SEL_BYPASS: sel_bit = byp_cell;
            SEL_RSTREG: sel_bit = rst_cell;
            default:    sel_bit = bsc_so;
         endcase
      end
   end

   jtag_tdo_out #(.IDLE(TDO_IDLE), .ON_FALL(TDO_ON_FALL)) u_tdo (
      .tck(tck), .rst_n(rst_n), .shifting(sft_ir | sft_dr),
      .bit_in(sel_bit), .tdo(tdo)
   );

   assign sys_rst_req = rst_cell;
   assign bsc_sel     = (dr_sel == SEL_BSC);
   assign bsc_cap     = bsc_sel & cap_dr;
   assign bsc_shift   = bsc_sel & sft_dr;
   assign bsc_upd     = bsc_sel & upd_dr;
endmodule

// File: rtl/jtag_ir_dr_sel_chk.sv
module jtag_ir_dr_sel_chk
   import jtag_sel_pkg::*;
#(
   parameter int              IR_W      = 4,
   parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'h1,
   parameter logic [IR_W-1:0] OP_SAMPLE = 4'h2,
   parameter logic            TDO_IDLE  = 1'b1
) (
   input logic            tck,
   input logic            rst_n,
   input logic            tlr,
   input logic            upd_ir,
   input logic            cap_dr,
   input logic            sft_dr,
   input logic            sft_ir,
   input logic            tdi,
   input logic [IR_W-1:0] ir_sh,
   input logic [IR_W-1:0] ir_act,
   input dr_sel_e         dr_sel,
   input logic            byp_cell,
   input logic            sys_rst_req,
   input logic            bsc_sel,
   input logic            bsc_drive,
   input logic            tdo
);
   AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
      tlr |=> (ir_act == OP_IDCODE && !sys_rst_req)); // R1
   AST_IR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
      (!upd_ir && !tlr) |=> $stable(ir_act)); // R2
   AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
      (cap_dr && dr_sel == SEL_BYPASS) |=> !byp_cell); // R4
   AST_RST_CELL_LIVE: assert property (@(posedge tck) disable iff (!rst_n)
      (sft_dr && dr_sel == SEL_RSTREG && !tlr) |=> (sys_rst_req == $past(tdi))); // R6
   AST_RST_REQ_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
      (!tlr && !(sft_dr && dr_sel == SEL_RSTREG)) |=> $stable(sys_rst_req)); // R7
   AST_EXTEST_DRIVE: assert property (@(posedge tck) disable iff (!rst_n)
      (upd_ir && !tlr && ir_sh == OP_EXTEST) |=> (bsc_sel && bsc_drive)); // R8
   AST_SAMPLE_NO_DRIVE: assert property (@(posedge tck) disable iff (!rst_n)
      (upd_ir && !tlr && ir_sh == OP_SAMPLE) |=> (bsc_sel && !bsc_drive)); // R9
   AST_TDO_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
      (!sft_dr && !sft_ir) |-> (tdo == TDO_IDLE)); // R10
endmodule

bind jtag_ir_dr_sel jtag_ir_dr_sel_chk #(
   .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_IDCODE(OP_IDCODE),
   .OP_SAMPLE(OP_SAMPLE), .TDO_IDLE(TDO_IDLE)
) u_chk (
   .tck(tck), .rst_n(rst_n), .tlr(tlr), .upd_ir(upd_ir), .cap_dr(cap_dr),
   .sft_dr(sft_dr), .sft_ir(sft_ir), .tdi(tdi), .ir_sh(ir_sh), .ir_act(ir_act),
   .dr_sel(dr_sel), .byp_cell(byp_cell), .sys_rst_req(sys_rst_req),
   .bsc_sel(bsc_sel), .bsc_drive(bsc_drive), .tdo(tdo)
);

// File: tb/jtag_ir_dr_sel_tb.sv
`timescale 1ns/1ps
module jtag_ir_dr_sel_tb;
   localparam logic [6:0] S_TLR = 7'b1000000, S_CI = 7'b0100000, S_SI = 7'b0010000,
                          S_UI  = 7'b0001000, S_CD = 7'b0000100, S_SD = 7'b0000010,
                          S_UD  = 7'b0000001, S_NO = 7'b0000000;
   localparam logic [31:0] IDV = 32'h1A5C_703F;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tlr = 0, cap_dr = 0, sft_dr = 0, upd_dr = 0, cap_ir = 0, sft_ir = 0, upd_ir = 0;
   logic tdi = 0, bsc_so = 0;
   logic tdo, sys_rst_req, bsc_sel, bsc_drive, bsc_cap, bsc_shift, bsc_upd;

   int n_chk = 0, n_bad = 0, cyc_n = 0;
   bit chk_en = 0, done = 0;
   string cur_req = "R1";

   // reference model state
   int m_act;
   bit ir_q[$];
   bit id_q[$];
   bit m_byp, m_rcell;
   logic prev_tdo = 1'b1;

   always #2.5 clk = ~clk;

   jtag_ir_dr_sel u_dut (
      .tck(clk), .rst_n(rst_n), .tlr(tlr), .cap_dr(cap_dr), .sft_dr(sft_dr),
      .upd_dr(upd_dr), .cap_ir(cap_ir), .sft_ir(sft_ir), .upd_ir(upd_ir),
      .tdi(tdi), .id_value(IDV), .bsc_so(bsc_so), .tdo(tdo),
      .sys_rst_req(sys_rst_req), .bsc_sel(bsc_sel), .bsc_drive(bsc_drive),
      .bsc_cap(bsc_cap), .bsc_shift(bsc_shift), .bsc_upd(bsc_upd)
   );

   function automatic int kind(int op); // 0 boundary, 1 id, 2 bypass, 3 reset
      if (op == 0 || op == 2) return 0;
      if (op == 1) return 1;
      if (op == 12) return 3;
      return 2;
   endfunction

   task automatic check(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b at cycle %0d", req, what, act, exp, cyc_n);
      end
   endtask

   // reference model: one step per rising edge
   always @(posedge clk) begin
      cyc_n++;
      if (!rst_n) begin
         m_act = 1; ir_q = '{1, 0, 0, 0}; m_byp = 0; m_rcell = 0;
         id_q.delete();
         for (int i = 0; i < 32; i++) id_q.push_back(1'b0);
      end else if (tlr) begin
         m_act = 1; m_rcell = 0;
      end else begin
         if (cap_ir) ir_q = '{1, 0, 0, 0};
         else if (sft_ir) begin void'(ir_q.pop_front()); ir_q.push_back(tdi); end
         if (upd_ir) m_act = ir_q[0] + 2 * ir_q[1] + 4 * ir_q[2] + 8 * ir_q[3];
         case (kind(m_act))
            1: if (cap_dr) begin
                  id_q.delete();
                  for (int i = 0; i < 32; i++) id_q.push_back(IDV[i]);
               end else if (sft_dr) begin
                  void'(id_q.pop_front()); id_q.push_back(tdi);
               end
            2: if (cap_dr) m_byp = 0; else if (sft_dr) m_byp = tdi;
            3: if (sft_dr) m_rcell = tdi;
            default: ;
         endcase
      end
   end

   // comparisons: TDO hold before the falling edge, everything after it
   always @(posedge clk) begin
      logic e_tdo;
      bit   sel;
      #2;
      if (chk_en) check("R10", "tdo before falling edge", tdo, prev_tdo);
      #2;
      if (chk_en) begin
         sel = (kind(m_act) == 0);
         if (sft_ir) e_tdo = ir_q[0];
         else if (sft_dr)
            case (kind(m_act))
               0: e_tdo = bsc_so;
               1: e_tdo = id_q[0];
               2: e_tdo = m_byp;
               default: e_tdo = m_rcell;
            endcase
         else e_tdo = 1'b1;
         check((sft_dr || sft_ir) ? cur_req : "R10", "tdo", tdo, e_tdo);
         check(cur_req, "sys_rst_req", sys_rst_req, m_rcell);
         check(cur_req, "bsc_sel", bsc_sel, sel);
         check(cur_req, "bsc_drive", bsc_drive, m_act == 0);
         check("R9", "bsc_cap", bsc_cap, sel & cap_dr);
         check("R9", "bsc_shift", bsc_shift, sel & sft_dr);
         check("R9", "bsc_upd", bsc_upd, sel & upd_dr);
         prev_tdo = e_tdo;
      end
   end

   task automatic tick(logic [6:0] s, logic d);
      @(posedge clk); #1;
      {tlr, cap_ir, sft_ir, upd_ir, cap_dr, sft_dr, upd_dr} = s;
      tdi = d;
      bsc_so = cyc_n[0] ^ cyc_n[2];
   endtask

   task automatic load_ir(logic [3:0] op);
      tick(S_CI, 0);
      for (int i = 0; i < 4; i++) tick(S_SI, op[i]);
      tick(S_UI, 0);
      tick(S_NO, 0);
   endtask

   task automatic scan_dr(int n, logic [63:0] pat);
      tick(S_CD, 0);
      for (int i = 0; i < n; i++) tick(S_SD, pat[i]);
      tick(S_UD, 0);
      tick(S_NO, 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1 chk_en = 1;
      cur_req = "R1"; tick(S_NO, 0); tick(S_NO, 0);
      cur_req = "R3"; scan_dr(40, 64'hF0F0_1234_5678_9ABC);
      cur_req = "R2"; load_ir(4'hF);
      tick(S_CI, 0); tick(S_SI, 1); tick(S_SI, 0); tick(S_SI, 1); tick(S_NO, 0);
      tick(S_SI, 1); tick(S_UI, 0); tick(S_NO, 0);
      cur_req = "R4"; load_ir(4'hF); scan_dr(10, 64'h2D3);
      cur_req = "R5"; load_ir(4'h5); scan_dr(6, 64'h15);
      load_ir(4'h7); scan_dr(5, 64'h0B);
      cur_req = "R6"; load_ir(4'hC);
      tick(S_SD, 1); tick(S_SD, 0); tick(S_SD, 1); tick(S_NO, 0);
      tick(S_CD, 0); tick(S_UD, 0); tick(S_NO, 0);
      cur_req = "R7"; load_ir(4'hF); scan_dr(4, 64'h0); load_ir(4'h1); scan_dr(8, 64'h00);
      cur_req = "R8"; load_ir(4'h0); scan_dr(6, 64'h2A);
      cur_req = "R9"; load_ir(4'h2); scan_dr(6, 64'h35);
      cur_req = "R6"; load_ir(4'hC); tick(S_SD, 0); tick(S_NO, 0);
      tick(S_SD, 1); tick(S_NO, 0);
      cur_req = "R1"; tick(S_TLR, 0); tick(S_NO, 0); scan_dr(34, 64'h3_0000_0001);
      cur_req = "R4"; load_ir(4'hA); tick(S_CD, 0); tick(S_SD, 1); tick(S_SD, 1);
      tick(S_CD, 0); tick(S_SD, 0); tick(S_NO, 0);
      tick(S_NO, 0);
      done = 1;
      summary();
      $finish;
   end
endmodule